// File: doc/BRIEF.md
# Fixed-Point Add/Subtract Flag Unit

This block is the integer add and subtract path of a processor execute stage. It is purely combinational. From two 64-bit register operands, a 16-bit immediate, a split 16-bit displacement, the next instruction address and the incoming carry, overflow and summary-overflow flags, it computes a 64-bit result. It also computes the new CA, CA32, OV, OV32, SO and a 4-bit CR0 field.

Every operation is reduced to one sum: operand A (register, inverted register, zero or program counter), plus operand B (register, all-ones, zero or an extended immediate), plus a carry-in (0, 1, CA or OV). A 5-bit operation code selects the variant. The decoder supplies two enables: one for overflow recording and one for CR0 recording. Flags that an operation does not write leave the unit equal to their inputs, so the unit's outputs can be written back unconditionally.

Top module: `addsub_flag_unit`

## Requirements
- R1: Operation codes are: 0 add, 1 subtract-from, 2 add-carrying, 3 subtract-from-carrying, 4 add-extended, 5 subtract-from-extended, 6 add-minus-one-extended, 7 subtract-from-minus-one-extended, 8 add-zero-extended, 9 subtract-from-zero-extended, 10 negate, 11 add-immediate, 12 add-immediate-shifted, 13 add-immediate-carrying, 14 add-immediate-carrying-recording, 15 subtract-from-immediate-carrying, 16 pc-relative-shifted, 17 alternate-carry add. Results follow the operation: add and add-carrying give ra+rb, subtract-from and subtract-from-carrying give rb-ra, and negate gives -ra, all modulo 2^64.
- R2: The extended forms add ca_i as carry-in. Codes 4/5 give ra+rb+ca and ~ra+rb+ca. Codes 6/7 add all-ones in place of rb, giving ra+ca-1 and ~ra+ca-1. Codes 8/9 add zero in place of rb, giving ra+ca and ~ra+ca.
- R3: Immediate forms use the sign-extended imm_i. Codes 11/12 add it to ra, or to zero when ra_field_zero_i=1. Code 12 first appends 16 zero bits to imm_i. Codes 13/14 give ra+imm. Code 15 gives imm-ra.
- R4: Code 16 forms D={disp_hi_i,disp_mid_i,disp_lo_i}, with disp_lo_i as the least significant bit. The result is nia_i plus D shifted left 16 bits and sign-extended.
- R5: Codes 2 to 9 and 13 to 15 write ca_o with the carry out of bit 63 and ca32_o with the carry out of bit 31 (bit 0 is the LSB). All other codes return ca_o=ca_i and ca32_o=ca32_i.
- R6: Code 17 computes ra+rb+ov_i. It writes ov_o with the carry out of bit 63 and ov32_o with the carry out of bit 31. It ignores oe_i and rc_i, and returns ca_i, ca32_i, so_i and cr0_i unchanged.
- R7: For codes 0 to 10 with oe_i=1, ov_o is the 64-bit signed overflow of the sum and ov32_o is the signed overflow of its low 32 bits. In that case so_o = so_i | ov_o. Otherwise, except for code 17, ov_o, ov32_o and so_o equal their inputs.
- R8: SO is sticky: so_i=1 always gives so_o=1.
- R9: CR0 is recorded for codes 0 to 10 with rc_i=1, and always for code 14. When recorded, cr0_o = {result<0, result>0, result==0, so_o}, using a signed compare. Otherwise cr0_o=cr0_i, and codes 11 to 13 and 15 to 17 ignore rc_i.
- R10: Whenever CR0 is recorded, exactly one of cr0_o[3:1] is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (R1) |
| ra_i | input | 64 | First register operand |
| rb_i | input | 64 | Second register operand |
| ra_field_zero_i | input | 1 | Register field of the first operand is 0 |
| imm_i | input | 16 | Signed immediate |
| disp_hi_i | input | 10 | Upper part of split displacement |
| disp_mid_i | input | 5 | Middle part of split displacement |
| disp_lo_i | input | 1 | Least significant displacement bit |
| nia_i | input | 64 | Next instruction address |
| ca_i | input | 1 | Current carry |
| ca32_i | input | 1 | Current 32-bit carry |
| ov_i | input | 1 | Current overflow |
| ov32_i | input | 1 | Current 32-bit overflow |
| so_i | input | 1 | Current summary overflow |
| cr0_i | input | 4 | Current CR0 field |
| oe_i | input | 1 | Overflow recording enable |
| rc_i | input | 1 | CR0 recording enable |
| result_o | output | 64 | Sum |
| ca_o | output | 1 | New carry |
| ca32_o | output | 1 | New 32-bit carry |
| ov_o | output | 1 | New overflow |
| ov32_o | output | 1 | New 32-bit overflow |
| so_o | output | 1 | New summary overflow |
| cr0_o | output | 4 | New CR0 field {LT,GT,EQ,SO} |

## Verification
The assertions assume that op_i holds one of the eighteen defined codes. Codes 18 to 31 are left without a defined outcome. The assertions also assume that inputs are stable whenever they are evaluated, since the block has no clock and the checks are immediate. The stimulus draws op_i only from 0 to 17 and changes inputs once per bench cycle, comparing after they settle. Operands are biased towards zero, all-ones and the signed extremes, so that carry and overflow boundaries are reached.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;

  typedef enum logic [4:0] {
    OP_ADD     = 5'd0,
    OP_SUBF    = 5'd1,
    OP_ADDC    = 5'd2,
    OP_SUBFC   = 5'd3,
    OP_ADDE    = 5'd4,
    OP_SUBFE   = 5'd5,
    OP_ADDME   = 5'd6,
    OP_SUBFME  = 5'd7,
    OP_ADDZE   = 5'd8,
    OP_SUBFZE  = 5'd9,
    OP_NEG     = 5'd10,
    OP_ADDI    = 5'd11,
    OP_ADDIS   = 5'd12,
    OP_ADDIC   = 5'd13,
    OP_ADDICR  = 5'd14,
    OP_SUBFIC  = 5'd15,
    OP_PCREL   = 5'd16,
    OP_ALTADD  = 5'd17
  } op_e;

  typedef enum logic [1:0] {
    ASRC_REG, ASRC_INV, ASRC_REG_OR_ZERO, ASRC_PC
  } a_src_e;

  typedef enum logic [2:0] {
    BSRC_REG, BSRC_ONES, BSRC_ZERO, BSRC_SIMM, BSRC_SIMM_HI, BSRC_DISP_HI
  } b_src_e;

  typedef enum logic [1:0] {
    CIN_ZERO, CIN_ONE, CIN_CA, CIN_OV
  } cin_e;

  typedef struct packed {
    a_src_e a_src;
    b_src_e b_src;
    cin_e   cin;
    logic   ca_wr;      // operation writes CA/CA32
    logic   flag_form;  // honours oe/rc enables
    logic   alt_carry;  // carry goes to OV/OV32
    logic   force_rec;  // always records CR0
  } op_ctl_t;

  function automatic op_ctl_t decode_op(logic [4:0] code);
    op_ctl_t c;
    c = '{a_src: ASRC_REG, b_src: BSRC_REG, cin: CIN_ZERO,
          ca_wr: 1'b0, flag_form: 1'b0, alt_carry: 1'b0, force_rec: 1'b0};
    case (code)
      OP_ADD:    begin c.flag_form = 1'b1; end
      OP_SUBF:   begin c.a_src = ASRC_INV; c.cin = CIN_ONE; c.flag_form = 1'b1; end
      OP_ADDC:   begin c.ca_wr = 1'b1; c.flag_form = 1'b1; end
      OP_SUBFC:  begin c.a_src = ASRC_INV; c.cin = CIN_ONE; c.ca_wr = 1'b1; c.flag_form = 1'b1; end
      OP_ADDE:   begin c.cin = CIN_CA; c.ca_wr = 1'b1; c.flag_form = 1'b1; end
      OP_SUBFE:  begin c.a_src = ASRC_INV; c.cin = CIN_CA; c.ca_wr = 1'b1; c.flag_form = 1'b1; end
      OP_ADDME:  begin c.b_src = BSRC_ONES; c.cin = CIN_CA; c.ca_wr = 1'b1; c.flag_form = 1'b1; end
      OP_SUBFME: begin c.a_src = ASRC_INV; c.b_src = BSRC_ONES; c.cin = CIN_CA;
                       c.ca_wr = 1'b1; c.flag_form = 1'b1; end
      OP_ADDZE:  begin c.b_src = BSRC_ZERO; c.cin = CIN_CA; c.ca_wr = 1'b1; c.flag_form = 1'b1; end
      OP_SUBFZE: begin c.a_src = ASRC_INV; c.b_src = BSRC_ZERO; c.cin = CIN_CA;
                       c.ca_wr = 1'b1; c.flag_form = 1'b1; end
      OP_NEG:    begin c.a_src = ASRC_INV; c.b_src = BSRC_ZERO; c.cin = CIN_ONE; c.flag_form = 1'b1; end
      OP_ADDI:   begin c.a_src = ASRC_REG_OR_ZERO; c.b_src = BSRC_SIMM; end
      OP_ADDIS:  begin c.a_src = ASRC_REG_OR_ZERO; c.b_src = BSRC_SIMM_HI; end
      OP_ADDIC:  begin c.b_src = BSRC_SIMM; c.ca_wr = 1'b1; end
      OP_ADDICR: begin c.b_src = BSRC_SIMM; c.ca_wr = 1'b1; c.force_rec = 1'b1; end
      OP_SUBFIC: begin c.a_src = ASRC_INV; c.b_src = BSRC_SIMM; c.cin = CIN_ONE; c.ca_wr = 1'b1; end
      OP_PCREL:  begin c.a_src = ASRC_PC; c.b_src = BSRC_DISP_HI; end
      OP_ALTADD: begin c.cin = CIN_OV; c.alt_carry = 1'b1; end
      default:   begin end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/addsub_operand_mux.sv
`timescale 1ns/1ps
module addsub_operand_mux
  import addsub_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16,
  parameter int DH_W  = 10,
  parameter int DM_W  = 5
) (
  input  a_src_e            a_src,
  input  b_src_e            b_src,
  input  cin_e              cin_src,
  input  logic [XLEN-1:0]   ra,
  input  logic [XLEN-1:0]   rb,
  input  logic              ra_zero,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DH_W-1:0]   disp_hi,
  input  logic [DM_W-1:0]   disp_mid,
  input  logic              disp_lo,
  input  logic [XLEN-1:0]   nia,
  input  logic              ca,
  input  logic              ov,
  output logic [XLEN-1:0]   op_a,
  output logic [XLEN-1:0]   op_b,
  output logic              cin
);
  localparam int DISP_W = DH_W + DM_W + 1;

  logic [DISP_W-1:0] disp;
  logic [XLEN-1:0]   simm, simm_hi, disp_hi_ext;

  assign disp        = {disp_hi, disp_mid, disp_lo};
  assign simm        = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign simm_hi     = {{(XLEN-2*IMM_W){imm[IMM_W-1]}}, imm, {IMM_W{1'b0}}};
  assign disp_hi_ext = {{(XLEN-2*DISP_W){disp[DISP_W-1]}}, disp, {DISP_W{1'b0}}};

  always_comb begin
    unique case (a_src)
      ASRC_INV:         op_a = ~ra;
      ASRC_REG_OR_ZERO: op_a = ra_zero ? '0 : ra;
      ASRC_PC:          op_a = nia;
      default:          op_a = ra;
    endcase
  end

  always_comb begin
    case (b_src)
      BSRC_ONES:    op_b = '1;
      BSRC_ZERO:    op_b = '0;
      BSRC_SIMM:    op_b = simm;
      BSRC_SIMM_HI: op_b = simm_hi;
      BSRC_DISP_HI: op_b = disp_hi_ext;
      default:      op_b = rb;
    endcase
  end

  always_comb begin
    unique case (cin_src)
      CIN_ONE: cin = 1'b1;
      CIN_CA:  cin = ca;
      CIN_OV:  cin = ov;
      default: cin = 1'b0;
    endcase
  end
endmodule

// File: rtl/addsub_carry_chain.sv
`timescale 1ns/1ps
module addsub_carry_chain #(
  parameter int XLEN    = 64,
  parameter int N_LANES = 2
) (
  input  logic [XLEN-1:0]    op_a,
  input  logic [XLEN-1:0]    op_b,
  input  logic               cin,
  output logic [XLEN-1:0]    sum,
  output logic [N_LANES-1:0] lane_cout,  // carry out of each lane's top bit
  output logic [N_LANES-1:0] lane_cmsb   // carry into each lane's top bit
);
  localparam int LW = XLEN / N_LANES;

  logic [N_LANES:0] carry;
  assign carry[0] = cin;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [LW-1:0] la, lb, part;
    logic          top_a, top_b, cm;
    assign la    = op_a[g*LW +: LW];
    assign lb    = op_b[g*LW +: LW];
    assign top_a = la[LW-1];
    assign top_b = lb[LW-1];
    // low LW-1 bits plus incoming carry; bit LW-1 of part is carry into the top bit
    assign part  = {1'b0, la[LW-2:0]} + {1'b0, lb[LW-2:0]} + {{(LW-1){1'b0}}, carry[g]};
    assign cm    = part[LW-1];
    assign sum[g*LW +: LW] = {top_a ^ top_b ^ cm, part[LW-2:0]};
    assign carry[g+1]      = (top_a & top_b) | (cm & (top_a ^ top_b));
    assign lane_cmsb[g]    = cm;
  end

  assign lane_cout = carry[N_LANES:1];
endmodule

// File: rtl/addsub_flag_logic.sv
`timescale 1ns/1ps
module addsub_flag_logic #(
  parameter int XLEN = 64
) (
  input  logic            ca_wr,
  input  logic            flag_form,
  input  logic            alt_carry,
  input  logic            force_rec,
  input  logic            oe,
  input  logic            rc,
  input  logic [XLEN-1:0] sum,
  input  logic            cout_full,
  input  logic            cout_half,
  input  logic            ovf_full,
  input  logic            ovf_half,
  input  logic            ca_in,
  input  logic            ca32_in,
  input  logic            ov_in,
  input  logic            ov32_in,
  input  logic            so_in,
  input  logic [3:0]      cr0_in,
  output logic            ca_out,
  output logic            ca32_out,
  output logic            ov_out,
  output logic            ov32_out,
  output logic            so_out,
  output logic [3:0]      cr0_out,
  output logic            ov_wr,
  output logic            cr0_wr
);
  logic oe_rec, is_neg, is_zero, is_pos;

  assign oe_rec = flag_form & oe;
  assign ov_wr  = alt_carry | oe_rec;
  assign cr0_wr = force_rec | (flag_form & rc);

  assign ca_out   = ca_wr ? cout_full : ca_in;
  assign ca32_out = ca_wr ? cout_half : ca32_in;

  always_comb begin
    ov_out   = ov_in;
    ov32_out = ov32_in;
    so_out   = so_in;
    if (alt_carry) begin
      ov_out   = cout_full;
      ov32_out = cout_half;
    end else if (oe_rec) begin
      ov_out   = ovf_full;
      ov32_out = ovf_half;
      so_out   = so_in | ovf_full;
    end
  end

  assign is_neg  = sum[XLEN-1];
  assign is_zero = ~|sum;
  assign is_pos  = ~is_neg & ~is_zero;

  assign cr0_out = cr0_wr ? {is_neg, is_pos, is_zero, so_out} : cr0_in;
endmodule

// File: rtl/addsub_flag_unit.sv
`timescale 1ns/1ps
module addsub_flag_unit
  import addsub_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16,
  parameter int DH_W  = 10,
  parameter int DM_W  = 5
) (
  input  logic [4:0]       op_i,
  input  logic [XLEN-1:0]  ra_i,
  input  logic [XLEN-1:0]  rb_i,
  input  logic             ra_field_zero_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [DH_W-1:0]  disp_hi_i,
  input  logic [DM_W-1:0]  disp_mid_i,
  input  logic             disp_lo_i,
  input  logic [XLEN-1:0]  nia_i,
  input  logic             ca_i,
  input  logic             ca32_i,
  input  logic             ov_i,
  input  logic             ov32_i,
  input  logic             so_i,
  input  logic [3:0]       cr0_i,
  input  logic             oe_i,
  input  logic             rc_i,
  output logic [XLEN-1:0]  result_o,
  output logic             ca_o,
  output logic             ca32_o,
  output logic             ov_o,
  output logic             ov32_o,
  output logic             so_o,
  output logic [3:0]       cr0_o
);
  localparam int N_LANES = 2;
  localparam int HALF_IX = N_LANES / 2 - 1;

  op_ctl_t           ctl;
  logic [XLEN-1:0]   op_a, op_b;
  logic              cin;
  logic [N_LANES-1:0] lane_cout, lane_cmsb;

  // named internal events, used by the checker
  logic c64_evt, c32_evt, ovf64_evt, ovf32_evt;
  logic ca_wr, ov_wr, cr0_wr, alt_mode;

  assign ctl      = decode_op(op_i);
  assign ca_wr    = ctl.ca_wr;
  assign alt_mode = ctl.alt_carry;

  addsub_operand_mux #(
    .XLEN(XLEN), .IMM_W(IMM_W), .DH_W(DH_W), .DM_W(DM_W)
  ) u_mux (
    .a_src(ctl.a_src), .b_src(ctl.b_src), .cin_src(ctl.cin),
    .ra(ra_i), .rb(rb_i), .ra_zero(ra_field_zero_i), .imm(imm_i),
    .disp_hi(disp_hi_i), .disp_mid(disp_mid_i), .disp_lo(disp_lo_i),
    .nia(nia_i), .ca(ca_i), .ov(ov_i),
    .op_a(op_a), .op_b(op_b), .cin(cin)
  );

  addsub_carry_chain #(.XLEN(XLEN), .N_LANES(N_LANES)) u_chain (
    .op_a(op_a), .op_b(op_b), .cin(cin),
    .sum(result_o), .lane_cout(lane_cout), .lane_cmsb(lane_cmsb)
  );

  assign c64_evt   = lane_cout[N_LANES-1];
  assign c32_evt   = lane_cout[HALF_IX];
  assign ovf64_evt = lane_cout[N_LANES-1] ^ lane_cmsb[N_LANES-1];
  assign ovf32_evt = lane_cout[HALF_IX] ^ lane_cmsb[HALF_IX];

  addsub_flag_logic #(.XLEN(XLEN)) u_flags (
    .ca_wr(ctl.ca_wr), .flag_form(ctl.flag_form), .alt_carry(ctl.alt_carry),
    .force_rec(ctl.force_rec), .oe(oe_i), .rc(rc_i), .sum(result_o),
    .cout_full(c64_evt), .cout_half(c32_evt),
    .ovf_full(ovf64_evt), .ovf_half(ovf32_evt),
    .ca_in(ca_i), .ca32_in(ca32_i), .ov_in(ov_i), .ov32_in(ov32_i),
    .so_in(so_i), .cr0_in(cr0_i),
    .ca_out(ca_o), .ca32_out(ca32_o), .ov_out(ov_o), .ov32_out(ov32_o),
    .so_out(so_o), .cr0_out(cr0_o), .ov_wr(ov_wr), .cr0_wr(cr0_wr)
  );
endmodule

// File: rtl/addsub_flag_unit_chk.sv
`timescale 1ns/1ps
module addsub_flag_unit_chk #(
  parameter int XLEN = 64
) (
  input logic [XLEN-1:0] result_o,
  input logic            ca_i,
  input logic            ca32_i,
  input logic            so_i,
  input logic            ca_o,
  input logic            ca32_o,
  input logic            ov_o,
  input logic            so_o,
  input logic [3:0]      cr0_o,
  input logic            ca_wr,
  input logic            ov_wr,
  input logic            cr0_wr,
  input logic            alt_mode
);
  always_comb begin
    // R8: summary overflow never clears
    if (so_i) a_r8_so_sticky: assert (so_o);
    // R5: carry flags untouched by non-carrying operations
    if (!ca_wr) a_r5_ca_hold: assert (ca_o == ca_i && ca32_o == ca32_i);
    // R7: a recorded overflow raises the summary bit
    if (ov_wr && !alt_mode && ov_o) a_r7_ov_sets_so: assert (so_o);
    // R6: alternate-carry add leaves CA and SO alone
    if (alt_mode) a_r6_alt_keeps_ca_so: assert (ca_o == ca_i && so_o == so_i);
    // R9: EQ bit and SO copy agree with result and new SO
    if (cr0_wr) a_r9_cr0_eq_so: assert (cr0_o[1] == (result_o == '0) && cr0_o[0] == so_o);
    // R10: exactly one of LT/GT/EQ
    if (cr0_wr) a_r10_cr0_onehot: assert ($countones(cr0_o[3:1]) == 1);
  end
endmodule

bind addsub_flag_unit addsub_flag_unit_chk #(.XLEN(XLEN)) u_chk (
  .result_o(result_o), .ca_i(ca_i), .ca32_i(ca32_i), .so_i(so_i),
  .ca_o(ca_o), .ca32_o(ca32_o), .ov_o(ov_o), .so_o(so_o), .cr0_o(cr0_o),
  .ca_wr(ca_wr), .ov_wr(ov_wr), .cr0_wr(cr0_wr), .alt_mode(alt_mode)
);

// File: tb/tb_addsub_flag_unit.sv
`timescale 1ns/1ps
module tb_addsub_flag_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  op = '0;
  logic [63:0] ra = '0, rb = '0, nia = '0;
  logic        rz = 1'b0;
  logic [15:0] imm = '0;
  logic [9:0]  dh = '0;
  logic [4:0]  dm = '0;
  logic        dl = 1'b0;
  logic        ca = 0, ca32 = 0, ov = 0, ov32 = 0, so = 0, oe = 0, rc = 0;
  logic [3:0]  cr0 = '0;

  logic [63:0] res;
  logic        ca_o, ca32_o, ov_o, ov32_o, so_o;
  logic [3:0]  cr0_o;

  int checks = 0;
  int failures = 0;

  addsub_flag_unit dut (
    .op_i(op), .ra_i(ra), .rb_i(rb), .ra_field_zero_i(rz), .imm_i(imm),
    .disp_hi_i(dh), .disp_mid_i(dm), .disp_lo_i(dl), .nia_i(nia),
    .ca_i(ca), .ca32_i(ca32), .ov_i(ov), .ov32_i(ov32), .so_i(so),
    .cr0_i(cr0), .oe_i(oe), .rc_i(rc),
    .result_o(res), .ca_o(ca_o), .ca32_o(ca32_o), .ov_o(ov_o),
    .ov32_o(ov32_o), .so_o(so_o), .cr0_o(cr0_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [15:0] v);
    return {{48{v[15]}}, v};
  endfunction

  // compute expectations from the requirements and compare all outputs
  task automatic verify();
    logic [63:0] x, y, er;
    logic        c, xo, cw, alt, rec;
    logic [64:0] s65;
    logic [32:0] s33;
    logic        o64, o32, e_ca, e_ca32, e_ov, e_ov32, e_so;
    logic [3:0]  e_cr0;
    logic [63:0] d_ext;
    string       rtag;
    d_ext = {{32{dh[9]}}, dh, dm, dl, 16'h0};
    x = ra; y = rb; c = 0; xo = (op <= 5'd10); cw = 0; alt = 0;
    rtag = "R1";
    case (op)
      5'd0:  begin er = ra + rb; end
      5'd1:  begin x = ~ra; c = 1; er = rb - ra; end
      5'd2:  begin cw = 1; er = ra + rb; end
      5'd3:  begin x = ~ra; c = 1; cw = 1; er = rb - ra; end
      5'd4:  begin c = ca; cw = 1; er = ra + rb + {63'd0, ca}; rtag = "R2"; end
      5'd5:  begin x = ~ra; c = ca; cw = 1; er = ~ra + rb + {63'd0, ca}; rtag = "R2"; end
      5'd6:  begin y = '1; c = ca; cw = 1; er = ra + {63'd0, ca} - 64'd1; rtag = "R2"; end
      5'd7:  begin x = ~ra; y = '1; c = ca; cw = 1; er = ~ra + {63'd0, ca} - 64'd1; rtag = "R2"; end
      5'd8:  begin y = '0; c = ca; cw = 1; er = ra + {63'd0, ca}; rtag = "R2"; end
      5'd9:  begin x = ~ra; y = '0; c = ca; cw = 1; er = ~ra + {63'd0, ca}; rtag = "R2"; end
      5'd10: begin x = ~ra; y = '0; c = 1; er = 64'd0 - ra; end
      5'd11: begin x = rz ? '0 : ra; y = sx(imm); er = x + y; rtag = "R3"; end
      5'd12: begin x = rz ? '0 : ra; y = sx(imm) << 16; er = x + y; rtag = "R3"; end
      5'd13, 5'd14: begin y = sx(imm); cw = 1; er = ra + sx(imm); rtag = "R3"; end
      5'd15: begin x = ~ra; y = sx(imm); c = 1; cw = 1; er = sx(imm) - ra; rtag = "R3"; end
      5'd16: begin x = nia; y = d_ext; er = nia + d_ext; rtag = "R4"; end
      default: begin c = ov; alt = 1; er = ra + rb + {63'd0, ov}; rtag = "R6"; end
    endcase
    s65 = {1'b0, x} + {1'b0, y} + {64'd0, c};
    s33 = {1'b0, x[31:0]} + {1'b0, y[31:0]} + {32'd0, c};
    o64 = (x[63] == y[63]) && (s65[63] != x[63]);
    o32 = (x[31] == y[31]) && (s33[31] != x[31]);
    e_ca   = cw ? s65[64] : ca;
    e_ca32 = cw ? s33[32] : ca32;
    if (alt) begin e_ov = s65[64]; e_ov32 = s33[32]; e_so = so; end
    else if (xo && oe) begin e_ov = o64; e_ov32 = o32; e_so = so | o64; end
    else begin e_ov = ov; e_ov32 = ov32; e_so = so; end
    rec = (xo && rc) || (op == 5'd14);
    e_cr0 = rec ? {$signed(er) < 0, $signed(er) > 0, er == 0, e_so} : cr0;
    #1;
    chk(rtag, "result", res, er);
    chk("R5", "ca", {63'd0, ca_o}, {63'd0, e_ca});
    chk("R5", "ca32", {63'd0, ca32_o}, {63'd0, e_ca32});
    chk(alt ? "R6" : "R7", "ov", {63'd0, ov_o}, {63'd0, e_ov});
    chk(alt ? "R6" : "R7", "ov32", {63'd0, ov32_o}, {63'd0, e_ov32});
    chk("R8", "so", {63'd0, so_o}, {63'd0, e_so});
    chk("R9", "cr0", {60'd0, cr0_o}, {60'd0, e_cr0});
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(5, 0))
      0: return 64'd0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      4: return {32'h0, $urandom} ^ 64'h0000_0000_8000_0000;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // idle state: all-zero inputs give all-zero outputs (R1 add of zeros)
    @(negedge clk); #1;
    chk("R1", "idle result", res, 64'd0);
    chk("R9", "idle cr0", {60'd0, cr0_o}, 64'd0);

    // R3 directed: shifted immediate with zero register field
    @(negedge clk);
    op = 5'd12; ra = 64'h1234; rz = 1; imm = 16'h8000; #1;
    chk("R3", "addis zero field", res, 64'hFFFF_FFFF_8000_0000);
    // R4 directed: displacement of one
    @(negedge clk);
    op = 5'd16; nia = 64'h1000; dh = 0; dm = 0; dl = 1; #1;
    chk("R4", "pcrel", res, 64'h0001_1000);
    // R7 directed: negate of most negative value overflows and sets SO
    @(negedge clk);
    op = 5'd10; ra = 64'h8000_0000_0000_0000; oe = 1; so = 0; rc = 1; #1;
    chk("R7", "neg ov", {63'd0, ov_o}, 64'd1);
    chk("R7", "neg so", {63'd0, so_o}, 64'd1);
    chk("R10", "cr0 one-hot", {61'd0, cr0_o[3:1]}, 64'b100);
    // R8 directed: SO stays set with no overflow recording
    @(negedge clk);
    op = 5'd0; ra = 1; rb = 1; oe = 0; so = 1; rc = 0; #1;
    chk("R8", "so sticky", {63'd0, so_o}, 64'd1);
    // R6 directed: alternate carry add consumes OV, ignores enables
    @(negedge clk);
    op = 5'd17; ra = '1; rb = 64'd0; ov = 1; ca = 0; oe = 1; rc = 1; cr0 = 4'hA; so = 0; #1;
    chk("R6", "altadd result", res, 64'd0);
    chk("R6", "altadd ov", {63'd0, ov_o}, 64'd1);
    chk("R6", "altadd cr0", {60'd0, cr0_o}, 64'hA);
    // R2 directed: minus-one with CA=0 on zero gives all-ones, no carry
    @(negedge clk);
    op = 5'd6; ra = 0; ca = 0; #1;
    chk("R2", "addme zero", res, '1);
    chk("R5", "addme ca", {63'd0, ca_o}, 64'd0);
    // R10 directed: zero result records EQ only
    @(negedge clk);
    op = 5'd1; ra = 64'd5; rb = 64'd5; rc = 1; oe = 0; #1;
    chk("R10", "cr0 eq", {61'd0, cr0_o[3:1]}, 64'b001);

    // directed corner vectors through the model
    for (int k = 0; k < 18; k++) begin
      @(negedge clk);
      op = k[4:0]; ra = 64'h7FFF_FFFF_7FFF_FFFF; rb = 64'h0000_0000_0000_0001;
      imm = 16'h7FFF; rz = 0; ca = 1; ov = 1; ca32 = 0; ov32 = 0; so = 0;
      oe = 1; rc = 1; cr0 = 4'h5; nia = '1; dh = 10'h3FF; dm = 5'h1F; dl = 1;
      verify();
    end

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      op = 5'($urandom_range(17, 0));
      ra = pick(); rb = pick(); nia = pick();
      rz = 1'($urandom); imm = 16'($urandom);
      dh = 10'($urandom); dm = 5'($urandom); dl = 1'($urandom);
      ca = 1'($urandom); ca32 = 1'($urandom); ov = 1'($urandom);
      ov32 = 1'($urandom); so = 1'($urandom); oe = 1'($urandom);
      rc = 1'($urandom); cr0 = 4'($urandom);
      verify();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule